// File: doc/BRIEF.md
# Mesh Barrier Synchronizer with Selectable Grouping Patterns

This block is a central barrier controller for a square K x K mesh of tiles. Tiles are numbered row-major, so tile `row*K + col`. Each tile has a one-bit request and a three-bit pattern code sampled with it, plus a one-bit completion pulse and a sticky error flag.

The pattern code says how the mesh is split into groups. There are seven choices:

- pairs of horizontal neighbours;
- horizontal pairs that wrap around the row ends;
- pairs of vertical neighbours;
- vertical pairs that wrap around the column ends;
- a whole row;
- a whole column;
- the entire mesh.

A tile that requests stays pending until its group completes. A group completes when every member is pending with the same pattern code. The controller then pulses completion to all members in the same cycle and clears their pending state. Groups are evaluated independently, so one pair may finish while other tiles are still waiting.

A tile takes part in only one barrier at a time. A request made while the tile is still pending is dropped and sets that tile's error flag. A request carrying the reserved pattern code is also dropped and flags an error. The error flags clear only on reset.

Top module: `mesh_barrier_sync`

## Requirements
- R1: While reset is high and in the cycle after it falls, every `sync_done_o` and `err_o` bit is 0 and no tile is pending.
- R2: A tile's request is held pending until its group completes. If the last member's request is sampled at rising edge n, `sync_done_o` is high for exactly the one cycle after edge n+1, for all members together. The members' pending state clears at that same edge.
- R3: Pattern code 0 (horizontal pairs) groups column c with column c^1 in the same row, giving columns (0,1), (2,3) and so on.
- R4: Pattern code 1 (horizontal ring pairs) groups odd column c with column c+1, and column K-1 with column 0 of the same row.
- R5: Pattern code 2 (vertical pairs) groups row r with row r^1 in the same column.
- R6: Pattern code 3 (vertical ring pairs) groups odd row r with row r+1, and row K-1 with row 0 of the same column.
- R7: Pattern code 4 groups all K tiles of a row. Pattern code 5 groups all K tiles of a column.
- R8: Pattern code 6 groups all K*K tiles. Completion needs every tile pending with code 6.
- R9: If members of a would-be group are pending with different pattern codes, that group does not complete and its tiles stay pending.
- R10: Separate groups complete independently. A complete pair is released while tiles outside it remain pending.
- R11: A request from a tile that is already pending is ignored: its stored pattern is kept and it does not count twice. It sets that tile's `err_o` bit, which stays set until reset.
- R12: Pattern code 7 is reserved. A request with it is ignored, the tile does not become pending, and the tile's `err_o` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_req_i | input | K*K | One request strobe per tile |
| sync_pat_i | input | 3*K*K | Pattern code per tile, tile t in bits [3t+2:3t] |
| sync_done_o | output | K*K | Registered one-cycle completion pulse per tile |
| err_o | output | K*K | Sticky per-tile error flag |

## Verification
The assertions check, on every cycle, the properties that do not depend on a scenario:
- completion is a single-cycle pulse;
- a pulse comes only from a pending tile, and that tile's pending state clears with it;
- error flags never drop, and duplicate or reserved requests raise them while the stored pattern stays unchanged;
- a horizontal pair, a row or the whole mesh always finishes together.

Only the bench scenarios can show the positive side: that each grouping actually forms the right members, including the ring pairs across the mesh edges. They also show that incomplete or mismatched groups stay pending, and that independent pairs release on their own.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int PAT_W = 3;

  typedef enum logic [PAT_W-1:0] {
    PAT_HPAIR = 3'd0,
    PAT_HRING = 3'd1,
    PAT_VPAIR = 3'd2,
    PAT_VRING = 3'd3,
    PAT_ROW   = 3'd4,
    PAT_COL   = 3'd5,
    PAT_ALL   = 3'd6,
    PAT_RSVD  = 3'd7
  } mbs_pat_e;

  // Partner index along one axis for the plain pairing: 0<->1, 2<->3, ...
  function automatic int pair_idx(input int i);
    return i ^ 1;
  endfunction

  // Partner index along one axis for the ring pairing: 1<->2, 3<->4, ..., (K-1)<->0
  function automatic int ring_idx(input int i, input int k);
    if ((i % 2) == 1) return (i + 1) % k;
    return (i + k - 1) % k;
  endfunction

endpackage

// File: rtl/mbs_tile_slot.sv
module mbs_tile_slot
  import mbs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             req_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic             group_done_i,
  output logic             pend_o,
  output logic [PAT_W-1:0] pat_o,
  output logic             done_o,
  output logic             err_o
);

  logic rsvd;
  logic accept;
  logic reject;

  assign rsvd   = (pat_i == PAT_RSVD);
  assign accept = req_i && !pend_o && !rsvd;
  assign reject = req_i && (pend_o || rsvd);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_o <= 1'b0;
      pat_o  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= group_done_i;
      if (group_done_i) begin
        pend_o <= 1'b0;
      end else if (accept) begin
        pend_o <= 1'b1;
        pat_o  <= pat_i;
      end
      if (reject) begin
        err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mbs_group_eval.sv
module mbs_group_eval
  import mbs_pkg::*;
#(
  parameter int K = 4
) (
  input  logic [K*K-1:0]            pend_i,
  input  logic [K*K-1:0][PAT_W-1:0] pat_i,
  output logic [K*K-1:0]            done_o
);

  localparam int N = K * K;

  logic [N-1:0] want_row;
  logic [N-1:0] want_col;
  logic [N-1:0] want_all;
  logic [K-1:0] row_ok;
  logic [K-1:0] col_ok;
  logic         all_ok;

  for (genvar t = 0; t < N; t++) begin : g_want
    assign want_row[t] = pend_i[t] && (pat_i[t] == PAT_ROW);
    assign want_col[t] = pend_i[t] && (pat_i[t] == PAT_COL);
    assign want_all[t] = pend_i[t] && (pat_i[t] == PAT_ALL);
  end

  for (genvar r = 0; r < K; r++) begin : g_row
    assign row_ok[r] = &want_row[r*K +: K];
  end

  always_comb begin
    for (int c = 0; c < K; c++) begin
      col_ok[c] = 1'b1;
      for (int r = 0; r < K; r++) begin
        col_ok[c] = col_ok[c] & want_col[r*K + c];
      end
    end
  end

  assign all_ok = &want_all;

  for (genvar t = 0; t < N; t++) begin : g_tile
    localparam int ROW = t / K;
    localparam int COL = t % K;
    localparam int HP  = ROW * K + pair_idx(COL);
    localparam int HR  = ROW * K + ring_idx(COL, K);
    localparam int VP  = pair_idx(ROW) * K + COL;
    localparam int VR  = ring_idx(ROW, K) * K + COL;

    logic hit;

    always_comb begin
      case (pat_i[t])
        PAT_HPAIR: hit = pend_i[HP] && (pat_i[HP] == PAT_HPAIR);
        PAT_HRING: hit = pend_i[HR] && (pat_i[HR] == PAT_HRING);
        PAT_VPAIR: hit = pend_i[VP] && (pat_i[VP] == PAT_VPAIR);
        PAT_VRING: hit = pend_i[VR] && (pat_i[VR] == PAT_VRING);
        PAT_ROW:   hit = row_ok[ROW];
        PAT_COL:   hit = col_ok[COL];
        PAT_ALL:   hit = all_ok;
        default:   hit = 1'b0;
      endcase
    end

    assign done_o[t] = pend_i[t] && hit;
  end

endmodule

// File: rtl/mesh_barrier_sync.sv
module mesh_barrier_sync
  import mbs_pkg::*;
#(
  parameter int K = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [K*K-1:0]       sync_req_i,
  input  logic [K*K*PAT_W-1:0] sync_pat_i,
  output logic [K*K-1:0]       sync_done_o,
  output logic [K*K-1:0]       err_o
);

  localparam int N = K * K;

  logic [N-1:0]            pend_w;
  logic [N-1:0][PAT_W-1:0] pat_w;
  logic [N-1:0]            grp_done_w;

  mbs_group_eval #(.K(K)) i_eval (
    .pend_i (pend_w),
    .pat_i  (pat_w),
    .done_o (grp_done_w)
  );

  for (genvar t = 0; t < N; t++) begin : g_slot
    mbs_tile_slot i_slot (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .req_i        (sync_req_i[t]),
      .pat_i        (sync_pat_i[t*PAT_W +: PAT_W]),
      .group_done_i (grp_done_w[t]),
      .pend_o       (pend_w[t]),
      .pat_o        (pat_w[t]),
      .done_o       (sync_done_o[t]),
      .err_o        (err_o[t])
    );
  end

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
  import mbs_pkg::*;
#(
  parameter int K = 4
) (
  input logic                      clk_i,
  input logic                      rst_i,
  input logic [K*K-1:0]            req,
  input logic [K*K*PAT_W-1:0]      pat_in,
  input logic [K*K-1:0]            done,
  input logic [K*K-1:0]            err,
  input logic [K*K-1:0]            pend,
  input logic [K*K-1:0][PAT_W-1:0] pat_q
);

  localparam int N = K * K;

  for (genvar t = 0; t < N; t++) begin : g_chk
    localparam int ROW = t / K;
    localparam int COL = t % K;
    localparam int HP  = ROW * K + pair_idx(COL);

    AST_DONE_FROM_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
      done[t] |-> $past(pend[t])) else $error("done without pending"); // R2
    AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      done[t] |-> !pend[t]) else $error("pending not cleared"); // R2
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      done[t] |=> !done[t]) else $error("done wider than one cycle"); // R2
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      err[t] |=> err[t]) else $error("error flag dropped"); // R11
    AST_DUP_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend[t] && req[t]) |=> err[t]) else $error("duplicate not flagged"); // R11
    AST_DUP_KEEPS_PAT: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend[t] && req[t]) |=> (pat_q[t] == $past(pat_q[t]))) else $error("pattern overwritten"); // R11
    AST_RSVD_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
      (req[t] && (pat_in[t*PAT_W +: PAT_W] == PAT_RSVD)) |=> err[t]) else $error("reserved not flagged"); // R12
    AST_HPAIR_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
      (done[t] && (pat_q[t] == PAT_HPAIR)) |-> done[HP]) else $error("pair split"); // R3
    AST_ROW_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
      (done[t] && (pat_q[t] == PAT_ROW)) |-> (&done[ROW*K +: K])) else $error("row split"); // R7
    AST_ALL_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
      (done[t] && (pat_q[t] == PAT_ALL)) |-> (&done)) else $error("global split"); // R8
  end

endmodule

bind mesh_barrier_sync mbs_checker #(.K(K)) i_mbs_checker (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .req    (sync_req_i),
  .pat_in (sync_pat_i),
  .done   (sync_done_o),
  .err    (err_o),
  .pend   (pend_w),
  .pat_q  (pat_w)
);

// File: tb/test_mesh_barrier_sync.sv
module test_mesh_barrier_sync;

  localparam int K = 4;
  localparam int N = K * K;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   req;
  logic [N*3-1:0] pat;
  logic [N-1:0]   done;
  logic [N-1:0]   err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mesh_barrier_sync #(.K(K)) i_mesh_barrier_sync (
    .clk_i       (clk),
    .rst_i       (rst),
    .sync_req_i  (req),
    .sync_pat_i  (pat),
    .sync_done_o (done),
    .err_o       (err)
  );

  // {pattern[2:0], request mask[15:0], expected release[15:0]}; tile = row*4 + col
  localparam logic [34:0] VEC [0:15] = '{
    {3'd0, 16'h0003, 16'h0003},  // R3 columns 0,1
    {3'd0, 16'h0006, 16'h0000},  // R3 columns 1,2 are not a pair
    {3'd1, 16'h0006, 16'h0006},  // R4 columns 1,2
    {3'd1, 16'h0009, 16'h0009},  // R4 ring columns 3,0
    {3'd1, 16'h0003, 16'h0000},  // R4 columns 0,1 are not a ring pair
    {3'd2, 16'h0011, 16'h0011},  // R5 rows 0,1
    {3'd2, 16'h0110, 16'h0000},  // R5 rows 1,2 are not a pair
    {3'd3, 16'h0110, 16'h0110},  // R6 rows 1,2
    {3'd3, 16'h1001, 16'h1001},  // R6 ring rows 3,0
    {3'd4, 16'h00F0, 16'h00F0},  // R7 whole row 1
    {3'd4, 16'h0070, 16'h0000},  // R7 row incomplete
    {3'd5, 16'h4444, 16'h4444},  // R7 whole column 2
    {3'd6, 16'hFFFF, 16'hFFFF},  // R8 all tiles
    {3'd6, 16'h7FFF, 16'h0000},  // R8 one tile missing
    {3'd0, 16'hFFFF, 16'hFFFF},  // R10 eight pairs at once
    {3'd0, 16'h0007, 16'h0003}   // R10 pair 0,1 completes, tile 2 waits
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = '0;
    pat = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [N-1:0] m, input logic [2:0] p);
    req = m;
    for (int t = 0; t < N; t++) pat[t*3 +: 3] = p;
  endtask

  // Requests in one cycle, then the release cycle is sampled, then the cycle after it.
  task automatic apply(input string tag, input logic [N-1:0] m, input logic [2:0] p,
                       input logic [N-1:0] exp);
    @(negedge clk);
    drive(m, p);
    @(negedge clk);
    req = '0;
    @(negedge clk);
    check(tag, 32'(done), 32'(exp));
    @(negedge clk);
    check({tag, " pulse"}, 32'(done), 32'h0);
  endtask

  initial begin
    rst = 1'b1;
    req = '0;
    pat = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", 32'(done), 32'h0);
    check("R1 err in reset", 32'(err), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", 32'(done), 32'h0);
    check("R1 err after reset", 32'(err), 32'h0);
    apply("R1 no tile pending after reset", 16'h0002, 3'd0, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      do_reset();
      apply($sformatf("vector %0d", i), VEC[i][31:16], VEC[i][34:32], VEC[i][15:0]);
    end

    // R10: leftover tile 2 from the last vector now completes with tile 3
    apply("R10 later pair", 16'h0008, 3'd0, 16'h000C);

    // R2: staggered requests, exact release cycle
    do_reset();
    @(negedge clk); drive(16'h0001, 3'd2);
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    check("R2 held pending, no early release", 32'(done), 32'h0);
    drive(16'h0010, 3'd2);
    @(negedge clk); req = '0;
    check("R2 not yet after capture edge", 32'(done), 32'h0);
    @(negedge clk);
    check("R2 release one edge later", 32'(done), 32'h0011);
    @(negedge clk);
    check("R2 single-cycle pulse", 32'(done), 32'h0);

    // R9: mismatched codes
    do_reset();
    apply("R9 tile0 code0", 16'h0001, 3'd0, 16'h0000);
    apply("R9 tile1 code1 mismatch", 16'h0002, 3'd1, 16'h0000);
    apply("R9 tile1 still pending, pairs with tile2", 16'h0004, 3'd1, 16'h0006);

    // R11: duplicate request
    do_reset();
    @(negedge clk); drive(16'h0001, 3'd0);
    @(negedge clk); drive(16'h0001, 3'd6);
    @(negedge clk); req = '0;
    check("R11 duplicate flags error", 32'(err), 32'h0001);
    apply("R11 stored pattern kept", 16'h0002, 3'd0, 16'h0003);
    check("R11 error sticky", 32'(err), 32'h0001);

    // R12: reserved code
    do_reset();
    @(negedge clk); drive(16'h0020, 3'd7);
    @(negedge clk); req = '0;
    @(negedge clk);
    check("R12 reserved flags error", 32'(err), 32'h0020);
    apply("R12 reserved tile not pending", 16'h0010, 3'd0, 16'h0000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule